// File: doc/BRIEF.md
# Extended-Range Jump, Call and Pointer Unit

This unit carries out the control-flow and pointer instructions that follow an escape prefix on a byte-wide processor whose address space has been widened to 24 bits. The instruction fetch logic strips the prefix and hands over the second opcode byte. It also supplies the 24-bit immediate, when the instruction has one, the current accumulator value, and the address of the next instruction. The unit then produces a new program counter together with a load strobe, a new accumulator value together with a load strobe, and a completion pulse.

The unit contains two pieces of state. The first is a 24-bit data pointer, used for indexed jumps, code-table reads and external data moves. The second is a byte-wide stack pointer for a stack that grows upward and sits at a fixed base address in memory. A long call stores its 3-byte return address one byte per cycle, low byte first, at rising addresses. A long return reads the three bytes back in the same order.

Memories sit outside the unit. Both the stack port and the data/code port use synchronous reads: read data appears in the cycle after the read strobe. An opcode is taken only while `busy` is low.

Top module: `xptr_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the stack pointer equals SP_RESET (default 0x07). The data pointer is 0. All strobes, `busy`, `done`, `pc_load` and `acc_load` are low.
- R2: Opcode 0x02 (long jump) raises `pc_load` and `done` in the cycle after acceptance, with `pc_out` equal to the 24-bit immediate.
- R3: Opcode 0x12 (long call) writes three stack bytes on three consecutive cycles, starting in the cycle after acceptance. The addresses are STACK_BASE + ((sp + k) mod 256) for k = 1, 2, 3, and the bytes are `pc_next` bits [7:0], [15:8] and [23:16] in that order. In the following cycle `pc_load` and `done` rise with `pc_out` equal to the immediate.
- R4: Opcode 0x22 (long return) issues three stack reads on consecutive cycles, starting in the cycle after acceptance. The addresses are STACK_BASE + ((sp − 2 + k) mod 256) for k = 0, 1, 2. Two cycles after the last read strobe, `pc_load` and `done` rise with `pc_out` = {byte at sp, byte at sp−1, byte at sp−2}.
- R5: A call adds 3 to the stack pointer and a return subtracts 3, both modulo 256. The stack pointer changes only in the cycle where `done` is high.
- R6: Opcode 0x90 loads the data pointer from the immediate. Opcode 0xA3 adds one to it modulo 2^24. Either change is visible on `ptr_out` in the cycle after acceptance, together with `done`.
- R7: Opcode 0x73 raises `pc_load` and `done` in the cycle after acceptance, with `pc_out` = (pointer + zero-extended accumulator) mod 2^24.
- R8: Opcode 0x93 raises `code_rd` with address pointer + accumulator. Opcode 0xE0 raises `mem_rd` with the pointer as address. Two cycles after that strobe, `acc_load` and `done` rise with `acc_out` equal to the returned byte, and `busy` is high in between.
- R9: Opcode 0xF0 raises `mem_wr` in the cycle after acceptance, with `mem_addr` equal to the pointer, `mem_wdata` equal to the accumulator, and `done` high.
- R10: An opcode presented while `busy` is high is ignored. Any opcode outside the nine listed above is ignored. An ignored opcode produces no strobe, no `done`, and no change to the pointers.
- R11: `done` is never high together with `busy`, and at most one of `stk_wr`, `stk_rd`, `mem_wr`, `mem_rd`, `code_rd` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode byte valid |
| op_code | input | 8 | Opcode byte following the prefix |
| op_imm | input | 24 | Immediate target or pointer value |
| acc_in | input | 8 | Current accumulator |
| pc_next | input | 24 | Address of the following instruction |
| busy | output | 1 | Multi-cycle operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 24 | New program counter |
| acc_load | output | 1 | Load `acc_out` into the accumulator |
| acc_out | output | 8 | Byte read for the accumulator |
| sp_out | output | 8 | Stack pointer |
| ptr_out | output | 24 | Data pointer |
| stk_addr | output | 24 | Stack memory address |
| stk_wdata | output | 8 | Stack write byte |
| stk_wr | output | 1 | Stack write strobe |
| stk_rd | output | 1 | Stack read strobe |
| stk_rdata | input | 8 | Stack read byte, one cycle after `stk_rd` |
| mem_addr | output | 24 | Data or code address |
| mem_wdata | output | 8 | Data write byte |
| mem_wr | output | 1 | Data write strobe |
| mem_rd | output | 1 | Data read strobe |
| code_rd | output | 1 | Code read strobe |
| mem_rdata | input | 8 | Data or code byte, one cycle after the read strobe |

## Verification
The bench nests 84 calls. This carries the stack pointer past 255 and back to a low value, and then unwinds with returns. If the wrap were carried into the address instead of held at 8 bits, bytes would land above the stack window and the returns would give back wrong addresses. If the byte order were swapped, or the pop started one slot off, every return target would be wrong. The indexed jump is swept over all 256 accumulator values from a pointer just below 2^24, so a missing carry or a sign-extended accumulator shows up at once. The bench also holds an opcode valid throughout a call and issues undefined opcodes. A design that accepts work while busy would then alter the data pointer or emit a stray strobe.

// File: rtl/xptr_pkg.sv
`timescale 1ns/1ps
package xptr_pkg;
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OPC_LJMP  = 8'h02;
  localparam logic [OPC_W-1:0] OPC_LCALL = 8'h12;
  localparam logic [OPC_W-1:0] OPC_LRET  = 8'h22;
  localparam logic [OPC_W-1:0] OPC_JIDX  = 8'h73;
  localparam logic [OPC_W-1:0] OPC_LDPTR = 8'h90;
  localparam logic [OPC_W-1:0] OPC_CRD   = 8'h93;
  localparam logic [OPC_W-1:0] OPC_INCP  = 8'hA3;
  localparam logic [OPC_W-1:0] OPC_XRD   = 8'hE0;
  localparam logic [OPC_W-1:0] OPC_XWR   = 8'hF0;

  typedef struct packed {
    logic ljmp;
    logic lcall;
    logic lret;
    logic jidx;
    logic ldptr;
    logic crd;
    logic incp;
    logic xrd;
    logic xwr;
  } xop_dec_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PUSH, SQ_POP} seq_state_e;
  typedef enum logic [1:0] {RD_IDLE, RD_WAIT, RD_TAKE} rd_state_e;
endpackage

// File: rtl/xptr_decode.sv
`timescale 1ns/1ps
module xptr_decode
  import xptr_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output xop_dec_t         dec
);
  always_comb begin
    dec       = '0;
    dec.ljmp  = (opc == OPC_LJMP);
    dec.lcall = (opc == OPC_LCALL);
    dec.lret  = (opc == OPC_LRET);
    dec.jidx  = (opc == OPC_JIDX);
    dec.ldptr = (opc == OPC_LDPTR);
    dec.crd   = (opc == OPC_CRD);
    dec.incp  = (opc == OPC_INCP);
    dec.xrd   = (opc == OPC_XRD);
    dec.xwr   = (opc == OPC_XWR);
  end
endmodule

// File: rtl/xptr_dptr.sv
`timescale 1ns/1ps
module xptr_dptr #(
  parameter int AW = 24,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          inc,
  input  logic [AW-1:0] load_val,
  input  logic [DW-1:0] acc,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] sum_o
);
  localparam logic [AW-1:0] STEP = AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_o <= '0;
    end else if (load) begin
      ptr_o <= load_val;
    end else if (inc) begin
      ptr_o <= ptr_o + STEP;
    end
  end

  // pointer plus zero-extended accumulator, wraps at 2^AW
  assign sum_o = ptr_o + AW'(acc);
endmodule

// File: rtl/xptr_stack.sv
`timescale 1ns/1ps
module xptr_stack
  import xptr_pkg::*;
#(
  parameter int            AW      = 24,
  parameter int            DW      = 8,
  parameter int            SPW     = 8,
  parameter logic [SPW-1:0] SP_INIT = 8'h07,
  parameter logic [AW-1:0]  BASE    = 24'h7F0000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push_go,
  input  logic           pop_go,
  input  logic [AW-1:0]  push_val,
  output logic [SPW-1:0] sp_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           pop_o,
  output logic [AW-1:0]  ret_val_o,
  output logic [AW-1:0]  stk_addr_o,
  output logic [DW-1:0]  stk_wdata_o,
  output logic           stk_wr_o,
  output logic           stk_rd_o,
  input  logic [DW-1:0]  stk_rdata_i
);
  localparam int NB = AW / DW;
  localparam int IW = $clog2(NB + 1);
  localparam logic [SPW-1:0] NB_S   = SPW'(NB);
  localparam logic [SPW-1:0] BACK_S = SPW'(NB - 1);
  localparam logic [SPW-1:0] ONE_S  = SPW'(1);
  localparam logic [IW-1:0]  NB_I   = IW'(NB);
  localparam logic [IW-1:0]  LAST_I = IW'(NB - 1);
  localparam logic [IW-1:0]  ONE_I  = IW'(1);

  seq_state_e     st;
  logic [IW-1:0]  idx;
  logic [IW-1:0]  ncap;
  logic [AW-1:0]  sh;
  logic           rd_seen;

  function automatic logic [AW-1:0] slot(input logic [SPW-1:0] off);
    return BASE + AW'(off);
  endfunction

  assign busy_o = (st != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_IDLE;
      sp_o        <= SP_INIT;
      idx         <= '0;
      ncap        <= '0;
      sh          <= '0;
      rd_seen     <= 1'b0;
      done_o      <= 1'b0;
      pop_o       <= 1'b0;
      ret_val_o   <= '0;
      stk_addr_o  <= '0;
      stk_wdata_o <= '0;
      stk_wr_o    <= 1'b0;
      stk_rd_o    <= 1'b0;
    end else begin
      done_o   <= 1'b0;
      stk_wr_o <= 1'b0;
      stk_rd_o <= 1'b0;
      rd_seen  <= stk_rd_o;
      case (st)
        SQ_IDLE: begin
          if (push_go) begin
            st          <= SQ_PUSH;
            stk_wr_o    <= 1'b1;
            stk_addr_o  <= slot(sp_o + ONE_S);
            stk_wdata_o <= push_val[DW-1:0];
            sh          <= push_val >> DW;
            idx         <= ONE_I;
          end else if (pop_go) begin
            st         <= SQ_POP;
            stk_rd_o   <= 1'b1;
            stk_addr_o <= slot(sp_o - BACK_S);
            idx        <= ONE_I;
            ncap       <= '0;
          end
        end
        SQ_PUSH: begin
          if (idx < NB_I) begin
            stk_wr_o    <= 1'b1;
            stk_addr_o  <= slot(sp_o + SPW'(idx) + ONE_S);
            stk_wdata_o <= sh[DW-1:0];
            sh          <= sh >> DW;
            idx         <= idx + ONE_I;
          end else begin
            st     <= SQ_IDLE;
            sp_o   <= sp_o + NB_S;
            done_o <= 1'b1;
            pop_o  <= 1'b0;
          end
        end
        SQ_POP: begin
          if (idx < NB_I) begin
            stk_rd_o   <= 1'b1;
            stk_addr_o <= slot(sp_o - BACK_S + SPW'(idx));
            idx        <= idx + ONE_I;
          end
          if (rd_seen) begin
            if (ncap == LAST_I) begin
              ret_val_o <= {stk_rdata_i, sh[AW-1:DW]};
              done_o    <= 1'b1;
              pop_o     <= 1'b1;
              sp_o      <= sp_o - NB_S;
              st        <= SQ_IDLE;
            end else begin
              sh   <= {stk_rdata_i, sh[AW-1:DW]};
              ncap <= ncap + ONE_I;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xptr_unit.sv
`timescale 1ns/1ps
module xptr_unit
  import xptr_pkg::*;
#(
  parameter int             ADDR_W     = 24,
  parameter int             DATA_W     = 8,
  parameter int             SP_W       = 8,
  parameter logic [SP_W-1:0] SP_RESET   = 8'h07,
  parameter logic [ADDR_W-1:0] STACK_BASE = 24'h7F0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [ADDR_W-1:0] op_imm,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [ADDR_W-1:0] pc_next,
  output logic              busy,
  output logic              done,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_out,
  output logic              acc_load,
  output logic [DATA_W-1:0] acc_out,
  output logic [SP_W-1:0]   sp_out,
  output logic [ADDR_W-1:0] ptr_out,
  output logic [ADDR_W-1:0] stk_addr,
  output logic [DATA_W-1:0] stk_wdata,
  output logic              stk_wr,
  output logic              stk_rd,
  input  logic [DATA_W-1:0] stk_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic              code_rd,
  input  logic [DATA_W-1:0] mem_rdata
);
  xop_dec_t          dec;
  logic              accept;
  logic              stk_busy, stk_done, stk_pop;
  logic [ADDR_W-1:0] stk_ret;
  logic [ADDR_W-1:0] idx_sum;
  rd_state_e         rdst;
  logic [ADDR_W-1:0] pc_q, tgt_q;
  logic              pcld_q, done_q;

  assign accept = op_valid & ~busy;

  xptr_decode u_dec (
    .opc (op_code),
    .dec (dec)
  );

  xptr_dptr #(.AW(ADDR_W), .DW(DATA_W)) u_dptr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept & dec.ldptr),
    .inc      (accept & dec.incp),
    .load_val (op_imm),
    .acc      (acc_in),
    .ptr_o    (ptr_out),
    .sum_o    (idx_sum)
  );

  xptr_stack #(
    .AW(ADDR_W), .DW(DATA_W), .SPW(SP_W), .SP_INIT(SP_RESET), .BASE(STACK_BASE)
  ) u_stk (
    .clk         (clk),
    .rst         (rst),
    .push_go     (accept & dec.lcall),
    .pop_go      (accept & dec.lret),
    .push_val    (pc_next),
    .sp_o        (sp_out),
    .busy_o      (stk_busy),
    .done_o      (stk_done),
    .pop_o       (stk_pop),
    .ret_val_o   (stk_ret),
    .stk_addr_o  (stk_addr),
    .stk_wdata_o (stk_wdata),
    .stk_wr_o    (stk_wr),
    .stk_rd_o    (stk_rd),
    .stk_rdata_i (stk_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdst      <= RD_IDLE;
      pc_q      <= '0;
      tgt_q     <= '0;
      pcld_q    <= 1'b0;
      done_q    <= 1'b0;
      acc_load  <= 1'b0;
      acc_out   <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wr    <= 1'b0;
      mem_rd    <= 1'b0;
      code_rd   <= 1'b0;
    end else begin
      pcld_q   <= 1'b0;
      done_q   <= 1'b0;
      acc_load <= 1'b0;
      mem_wr   <= 1'b0;
      mem_rd   <= 1'b0;
      code_rd  <= 1'b0;
      if (stk_done) begin
        pc_q <= stk_pop ? stk_ret : tgt_q;
      end
      if (accept) begin
        if (dec.ljmp) begin
          pc_q   <= op_imm;
          pcld_q <= 1'b1;
          done_q <= 1'b1;
        end else if (dec.jidx) begin
          pc_q   <= idx_sum;
          pcld_q <= 1'b1;
          done_q <= 1'b1;
        end else if (dec.ldptr | dec.incp) begin
          done_q <= 1'b1;
        end else if (dec.xwr) begin
          mem_wr    <= 1'b1;
          mem_addr  <= ptr_out;
          mem_wdata <= acc_in;
          done_q    <= 1'b1;
        end else if (dec.xrd) begin
          mem_rd   <= 1'b1;
          mem_addr <= ptr_out;
          rdst     <= RD_WAIT;
        end else if (dec.crd) begin
          code_rd  <= 1'b1;
          mem_addr <= idx_sum;
          rdst     <= RD_WAIT;
        end else if (dec.lcall) begin
          tgt_q <= op_imm;
        end
      end
      case (rdst)
        RD_WAIT: rdst <= RD_TAKE;
        RD_TAKE: begin
          acc_out  <= mem_rdata;
          acc_load <= 1'b1;
          done_q   <= 1'b1;
          rdst     <= RD_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign busy    = (rdst != RD_IDLE) | stk_busy;
  assign done    = done_q | stk_done;
  assign pc_load = pcld_q | stk_done;
  assign pc_out  = stk_done ? (stk_pop ? stk_ret : tgt_q) : pc_q;
endmodule

// File: rtl/xptr_unit_chk.sv
`timescale 1ns/1ps
module xptr_unit_chk #(
  parameter int SPW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           op_valid,
  input logic           busy,
  input logic           done,
  input logic           pc_load,
  input logic [SPW-1:0] sp_out,
  input logic           stk_wr,
  input logic           stk_rd,
  input logic           mem_wr,
  input logic           mem_rd,
  input logic           code_rd
);
  localparam logic [SPW-1:0] STEP3 = SPW'(3);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stk_wr, stk_rd, mem_wr, mem_rd, code_rd}));

  assert_pcload_done_R2: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> done);

  assert_sp_step_R5: assert property (@(posedge clk) disable iff (rst)
    (sp_out != $past(sp_out)) |->
      (done && (((sp_out - $past(sp_out)) == STEP3) || (($past(sp_out) - sp_out) == STEP3))));

  assert_read_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || code_rd) |=> (busy && !done));

  assert_stack_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (stk_wr || stk_rd) |-> (busy && !done));

  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(op_valid));
endmodule

bind xptr_unit xptr_unit_chk #(.SPW(SP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .busy     (busy),
  .done     (done),
  .pc_load  (pc_load),
  .sp_out   (sp_out),
  .stk_wr   (stk_wr),
  .stk_rd   (stk_rd),
  .mem_wr   (mem_wr),
  .mem_rd   (mem_rd),
  .code_rd  (code_rd)
);

// File: tb/test_xptr_unit.sv
`timescale 1ns/1ps
module test_xptr_unit;
  localparam logic [23:0] BASE = 24'h7F0000;
  localparam logic [7:0]  SP0  = 8'h07;
  localparam int          NCALL = 84;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = '0;
  logic [23:0] op_imm = '0;
  logic [7:0]  acc_in = '0;
  logic [23:0] pc_next = '0;
  logic        busy, done, pc_load, acc_load;
  logic [23:0] pc_out, ptr_out, stk_addr, mem_addr;
  logic [7:0]  acc_out, sp_out, stk_wdata, mem_wdata;
  logic        stk_wr, stk_rd, mem_wr, mem_rd, code_rd;
  logic [7:0]  stk_rdata, mem_rdata;

  logic [7:0]  stk_mem [256];
  logic [7:0]  xmem [256];
  logic [7:0]  cmem [256];
  logic [23:0] shadow [NCALL];

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0]  sp_m = SP0;
  logic [23:0] ptr_m = '0;

  always #2.5 clk = ~clk;

  xptr_unit i_xptr_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_imm(op_imm),
    .acc_in(acc_in), .pc_next(pc_next), .busy(busy), .done(done), .pc_load(pc_load),
    .pc_out(pc_out), .acc_load(acc_load), .acc_out(acc_out), .sp_out(sp_out),
    .ptr_out(ptr_out), .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_wr(stk_wr),
    .stk_rd(stk_rd), .stk_rdata(stk_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .code_rd(code_rd), .mem_rdata(mem_rdata)
  );

  // synchronous memories: read data one cycle after the strobe
  always @(posedge clk) begin
    if (stk_wr) stk_mem[stk_addr[7:0]] <= stk_wdata;
    if (stk_rd) stk_rdata <= stk_mem[stk_addr[7:0]];
    if (mem_wr) xmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= xmem[mem_addr[7:0]];
    else if (code_rd) mem_rdata <= cmem[mem_addr[7:0]];
  end

  function automatic logic [7:0] code_byte(input int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // drive one opcode; returns at the falling edge after the accepting edge
  task automatic issue(input logic [7:0] op, input logic [23:0] imm,
                       input logic [7:0] acc, input logic [23:0] pcn);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; op_imm = imm; acc_in = acc; pc_next = pcn;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_ljmp(input logic [23:0] tgt);
    issue(8'h02, tgt, 8'h00, 24'h0);
    chk("R2 pc_load", 32'(pc_load), 32'd1);
    chk("R2 pc_out", 32'(pc_out), 32'(tgt));
    chk("R2 done", 32'(done), 32'd1);
  endtask

  task automatic t_ldptr(input logic [23:0] v);
    issue(8'h90, v, 8'h00, 24'h0);
    ptr_m = v;
    chk("R6 load ptr", 32'(ptr_out), 32'(ptr_m));
    chk("R6 load done", 32'(done), 32'd1);
  endtask

  task automatic t_incp();
    issue(8'hA3, 24'h0, 8'h00, 24'h0);
    ptr_m = ptr_m + 24'd1;
    chk("R6 inc ptr", 32'(ptr_out), 32'(ptr_m));
  endtask

  task automatic t_jidx(input logic [7:0] a);
    issue(8'h73, 24'h0, a, 24'h0);
    chk("R7 pc_load", 32'(pc_load), 32'd1);
    chk("R7 pc_out", 32'(pc_out), 32'(24'(ptr_m + {16'h0, a})));
  endtask

  task automatic t_xwr(input logic [7:0] a);
    issue(8'hF0, 24'h0, a, 24'h0);
    chk("R9 mem_wr", 32'(mem_wr), 32'd1);
    chk("R9 mem_addr", 32'(mem_addr), 32'(ptr_m));
    chk("R9 mem_wdata", 32'(mem_wdata), 32'(a));
    chk("R9 done", 32'(done), 32'd1);
  endtask

  task automatic t_read(input bit code, input logic [7:0] a, input logic [7:0] exp);
    issue(code ? 8'h93 : 8'hE0, 24'h0, a, 24'h0);
    chk("R8 strobe", 32'({code_rd, mem_rd}), code ? 32'd2 : 32'd1);
    chk("R8 addr", 32'(mem_addr), code ? 32'(24'(ptr_m + {16'h0, a})) : 32'(ptr_m));
    @(negedge clk);
    chk("R8 wait busy", 32'({busy, done}), 32'd2);
    @(negedge clk);
    chk("R8 acc_load", 32'({acc_load, done, busy}), 32'd6);
    chk("R8 acc_out", 32'(acc_out), 32'(exp));
  endtask

  task automatic t_call(input logic [23:0] tgt, input logic [23:0] pcn, input bit noise);
    issue(8'h12, tgt, 8'h00, pcn);
    for (int k = 0; k < 3; k++) begin
      chk("R3 stk_wr", 32'({stk_wr, done}), 32'd2);
      chk("R3 stk_addr", 32'(stk_addr), 32'(BASE + {16'h0, 8'(sp_m + 8'(k) + 8'd1)}));
      chk("R3 stk_wdata", 32'(stk_wdata), 32'(pcn[8*k +: 8]));
      chk("R5 sp held", 32'(sp_out), 32'(sp_m));
      if (noise) begin
        op_valid = 1'b1; op_code = 8'h90; op_imm = 24'hABCDEF;
      end
      @(negedge clk);
    end
    op_valid = 1'b0;
    chk("R3 finish", 32'({pc_load, done, stk_wr, busy}), 32'hC);
    chk("R3 pc_out", 32'(pc_out), 32'(tgt));
    sp_m = sp_m + 8'd3;
    chk("R5 sp up", 32'(sp_out), 32'(sp_m));
  endtask

  task automatic t_ret(input logic [23:0] exp_pc);
    issue(8'h22, 24'h0, 8'h00, 24'h0);
    for (int k = 0; k < 3; k++) begin
      chk("R4 stk_rd", 32'(stk_rd), 32'd1);
      chk("R4 stk_addr", 32'(stk_addr), 32'(BASE + {16'h0, 8'(sp_m - 8'd2 + 8'(k))}));
      @(negedge clk);
    end
    chk("R4 gap", 32'({stk_rd, busy, done}), 32'd2);
    @(negedge clk);
    chk("R4 finish", 32'({pc_load, done, busy}), 32'd6);
    chk("R4 pc_out", 32'(pc_out), 32'(exp_pc));
    sp_m = sp_m - 8'd3;
    chk("R5 sp down", 32'(sp_out), 32'(sp_m));
  endtask

  task automatic t_bad(input logic [7:0] op);
    issue(op, 24'h123456, 8'h44, 24'h654321);
    chk("R10 no action", 32'({done, busy, pc_load, acc_load, stk_wr, stk_rd, mem_wr, mem_rd, code_rd}), 32'd0);
    @(negedge clk);
    chk("R10 idle later", 32'({done, busy, stk_wr, stk_rd, mem_wr, mem_rd, code_rd}), 32'd0);
    chk("R10 ptr kept", 32'(ptr_out), 32'(ptr_m));
    chk("R10 sp kept", 32'(sp_out), 32'(sp_m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    wrap_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      cmem[i] = code_byte(i);
      stk_mem[i] = 8'h00;
      xmem[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    chk("R1 in reset sp", 32'(sp_out), 32'(SP0));
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sp", 32'(sp_out), 32'(SP0));
    chk("R1 ptr", 32'(ptr_out), 32'd0);
    chk("R1 outputs", 32'({busy, done, pc_load, acc_load, stk_wr, stk_rd, mem_wr, mem_rd, code_rd}), 32'd0);

    t_ljmp(24'h000000);
    t_ljmp(24'hFFFFFF);
    t_ljmp(24'h5A3C96);

    t_ldptr(24'h123456);
    t_incp();
    t_ldptr(24'hFFFFFF);
    t_incp();

    t_ldptr(24'hFFFF80);
    for (int a = 0; a < 256; a++) t_jidx(8'(a));

    t_ldptr(24'h000040);
    for (int i = 0; i < 16; i++) begin
      t_xwr(8'(i * 13 + 5));
      t_incp();
    end
    t_ldptr(24'h000040);
    for (int i = 0; i < 16; i++) begin
      t_read(1'b0, 8'h00, 8'(i * 13 + 5));
      t_incp();
    end
    t_ldptr(24'h000020);
    for (int a = 0; a < 256; a += 17) t_read(1'b1, 8'(a), code_byte(32 + a));

    t_bad(8'h55);
    t_bad(8'hA5);
    t_bad(8'h00);

    for (int i = 0; i < NCALL; i++) begin
      shadow[i] = 24'(i * 24'h010305 + 24'h0A0B0C);
      t_call(24'(24'hC00000 + i), shadow[i], (i % 7) == 0);
    end
    chk("R10 busy op ignored", 32'(ptr_out), 32'(ptr_m));
    for (int i = NCALL - 1; i >= 0; i--) t_ret(shadow[i]);
    chk("R5 sp restored", 32'(sp_out), 32'(SP0));

    repeat (3) @(negedge clk);
    wrap_up();
  end
endmodule